// File: doc/BRIEF.md
# Configurable Output Driver Controller

This block sits between a power sequencer and a bank of analog output pads. For every pad it picks one data bit from three candidates: the sequencer's decision, a bit that software wrote through a register, or a 100 kHz square wave. It then turns that pad's drive-mode field into digital controls for the analog driver. Those controls are a strong pull-down, a weak pull-up, a push-pull high side, a pull-up target (the core supply or one of four monitored rails) and a charge-pumped high-voltage drive.

Until the configuration flag says the setup has been latched, every pad is held with all controls off. In that state only the pad's passive weak pull-down acts. The square wave comes from a divider of the system clock, and that divider is also held in reset until the latch. Every control leaves the block through a register, so a change of data or configuration appears one clock later.

Top module: `drv_out_ctrl`

## Requirements
- R1: Configuration bits [1:0] of pad i (in cfg_word[7i+6:7i]) select its data. 00 selects seq_data[i] and 01 selects sw_data[i]. 10 selects the divided clock. 11 forces the data to 0. The pad controls show the result of the inputs sampled at one clock edge right after that edge (one cycle of latency).
- R2: While cfg_latched is 0, every pad's controls (pd_en, wpu_en, pp_en, rail_up, rail_sel, hv_en) are 0 one cycle later, whatever the configuration and data.
- R3: Mode bits [4:2] = 0 (open-drain): pd_en = NOT data. All other controls are 0.
- R4: Mode 1 (weak pull-up to core) and mode 3 (weak pull-up to a rail): pd_en = NOT data and wpu_en = data. In mode 3, rail_up is 1 and rail_sel equals bits [6:5]. In every mode other than 3 and 4, rail_up and rail_sel are 0.
- R5: Mode 2 (push-pull to core) and mode 4 (push-pull to a rail): pd_en = NOT data and pp_en = data. In mode 4, rail_up = 1 and rail_sel = bits [6:5]. pd_en is never 1 in the same cycle as wpu_en, pp_en or hv_en.
- R6: Mode 5 (strong sink): pd_en = 1 regardless of data. All other controls are 0.
- R7: Mode 6 (high-voltage drive): on pads 0 to HV_OUTS-1, hv_en = data and pd_en = NOT data. On higher pads, mode 6 behaves exactly like mode 0 and hv_en stays 0.
- R8: Mode 7 (reserved) sets all controls of the pad to 0.
- R9: The divided clock is high for SYS_CLK_HZ/(2*TICK_HZ) cycles, then low for the same count. It stays low while cfg_latched is 0. After cfg_latched rises, a pad fed from the clock shows its first high half-period + 1 cycles after the first edge that samples the flag.
- R10: During reset all pad controls are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_latched | input | 1 | Configuration has been downloaded and latched |
| seq_data | input | N_OUT | Sequencer data bit per pad |
| sw_data | input | N_OUT | Software-written data bit per pad |
| cfg_word | input | 7*N_OUT | Per-pad config: [1:0] source, [4:2] mode, [6:5] rail |
| pd_en | output | N_OUT | Strong pull-down enable |
| wpu_en | output | N_OUT | Weak pull-up enable |
| pp_en | output | N_OUT | Push-pull high-side enable |
| rail_up | output | N_OUT | Pull-up target: 1 = monitored rail, 0 = core supply |
| rail_sel | output | 2*N_OUT | Monitored rail index per pad |
| hv_en | output | N_OUT | Charge-pumped high-voltage drive enable |

## Verification
Random vectors draw a source, a mode and a rail field for every pad together with random data and an occasional deasserted latch flag. A wrong source mux, a swapped pull-up or push-pull mode, or a wrong rail field shows up in some pad's control word. Directed vectors put mode 6 on the last high-voltage pad and on the first pad above it, which separates an off-by-one in the high-voltage range from a correct design. A clock-sourced run measures the delay from the latch to the first high phase and the lengths of the high and low phases. That run tells a divider that free-runs before the latch, or a wrong half-period, from the intended one.

// File: rtl/drv_out_pkg.sv
`timescale 1ns/1ps
package drv_out_pkg;

  localparam int CFG_W = 7;

  typedef enum logic [1:0] {
    SRC_SEQ  = 2'b00,
    SRC_SW   = 2'b01,
    SRC_TICK = 2'b10,
    SRC_NONE = 2'b11
  } src_e;

  typedef enum logic [2:0] {
    DM_OD          = 3'd0,
    DM_OD_WPU_CORE = 3'd1,
    DM_PP_CORE     = 3'd2,
    DM_OD_WPU_RAIL = 3'd3,
    DM_PP_RAIL     = 3'd4,
    DM_SINK        = 3'd5,
    DM_HV          = 3'd6,
    DM_SAFE        = 3'd7
  } mode_e;

  // packed MSB first: rail [6:5], mode [4:2], src [1:0]
  typedef struct packed {
    logic [1:0] rail;
    mode_e      mode;
    src_e       src;
  } cfg_t;

  typedef struct packed {
    logic       pd;
    logic       wpu;
    logic       pp;
    logic       rail_up;
    logic [1:0] rail_sel;
    logic       hv;
  } pad_t;

  localparam pad_t PAD_SAFE = '0;

  function automatic logic pick_src(src_e s, logic seq_bit, logic sw_bit, logic tick);
    logic d;
    case (s)
      SRC_SEQ:  d = seq_bit;
      SRC_SW:   d = sw_bit;
      SRC_TICK: d = tick;
      default:  d = 1'b0;
    endcase
    return d;
  endfunction

  function automatic pad_t decode_drive(cfg_t c, logic d, logic hv_ok);
    pad_t p;
    p = PAD_SAFE;
    case (c.mode)
      DM_OD: p.pd = ~d;
      DM_OD_WPU_CORE: begin
        p.pd  = ~d;
        p.wpu = d;
      end
      DM_PP_CORE: begin
        p.pd = ~d;
        p.pp = d;
      end
      DM_OD_WPU_RAIL: begin
        p.pd       = ~d;
        p.wpu      = d;
        p.rail_up  = 1'b1;
        p.rail_sel = c.rail;
      end
      DM_PP_RAIL: begin
        p.pd       = ~d;
        p.pp       = d;
        p.rail_up  = 1'b1;
        p.rail_sel = c.rail;
      end
      DM_SINK: p.pd = 1'b1;
      DM_HV: begin
        p.pd = ~d;
        p.hv = d & hv_ok;
      end
      default: p = PAD_SAFE;
    endcase
    return p;
  endfunction

endpackage

// File: rtl/drv_tick_gen.sv
`timescale 1ns/1ps
module drv_tick_gen #(
  parameter int HALF = 1250
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic tick_q,
  output logic wrap_o
);
  localparam int CW = (HALF > 1) ? $clog2(HALF) : 1;
  localparam logic [CW-1:0] LAST = CW'(HALF - 1);

  logic [CW-1:0] cnt_q;

  assign wrap_o = run && (cnt_q == LAST);

  always_ff @(posedge clk) begin
    if (!rst_n || !run) begin
      cnt_q  <= '0;
      tick_q <= 1'b0;
    end else if (wrap_o) begin
      cnt_q  <= '0;
      tick_q <= ~tick_q;
    end else begin
      cnt_q  <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/drv_pin_slice.sv
`timescale 1ns/1ps
module drv_pin_slice
  import drv_out_pkg::*;
#(
  parameter bit HV_OK = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic latched,
  input  cfg_t cfg,
  input  logic seq_bit,
  input  logic sw_bit,
  input  logic tick,
  output logic data_o,
  output pad_t pad_q
);
  pad_t pad_d;

  assign data_o = pick_src(cfg.src, seq_bit, sw_bit, tick);

  always_comb begin
    if (latched) pad_d = decode_drive(cfg, data_o, HV_OK);
    else         pad_d = PAD_SAFE;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) pad_q <= PAD_SAFE;
    else        pad_q <= pad_d;
  end
endmodule

// File: rtl/drv_out_ctrl.sv
`timescale 1ns/1ps
module drv_out_ctrl
  import drv_out_pkg::*;
#(
  parameter int N_OUT      = 10,
  parameter int HV_OUTS    = 6,
  parameter int SYS_CLK_HZ = 250_000_000,
  parameter int TICK_HZ    = 100_000
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   cfg_latched,
  input  logic [N_OUT-1:0]       seq_data,
  input  logic [N_OUT-1:0]       sw_data,
  input  logic [N_OUT*CFG_W-1:0] cfg_word,
  output logic [N_OUT-1:0]       pd_en,
  output logic [N_OUT-1:0]       wpu_en,
  output logic [N_OUT-1:0]       pp_en,
  output logic [N_OUT-1:0]       rail_up,
  output logic [2*N_OUT-1:0]     rail_sel,
  output logic [N_OUT-1:0]       hv_en
);
  localparam int HALF_RAW = SYS_CLK_HZ / (2 * TICK_HZ);
  localparam int HALF     = (HALF_RAW > 0) ? HALF_RAW : 1;

  logic             tick_q;
  logic             tick_wrap;
  logic [N_OUT-1:0] pin_data;

  drv_tick_gen #(.HALF(HALF)) tick_i (
    .clk    (clk),
    .rst_n  (rst_n),
    .run    (cfg_latched),
    .tick_q (tick_q),
    .wrap_o (tick_wrap)
  );

  for (genvar i = 0; i < N_OUT; i++) begin : g_pin
    cfg_t cfg_i;
    pad_t pad_i;

    assign cfg_i = cfg_t'(cfg_word[i*CFG_W +: CFG_W]);

    drv_pin_slice #(.HV_OK(i < HV_OUTS)) slice_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .latched (cfg_latched),
      .cfg     (cfg_i),
      .seq_bit (seq_data[i]),
      .sw_bit  (sw_data[i]),
      .tick    (tick_q),
      .data_o  (pin_data[i]),
      .pad_q   (pad_i)
    );

    assign pd_en[i]         = pad_i.pd;
    assign wpu_en[i]        = pad_i.wpu;
    assign pp_en[i]         = pad_i.pp;
    assign rail_up[i]       = pad_i.rail_up;
    assign rail_sel[2*i +: 2] = pad_i.rail_sel;
    assign hv_en[i]         = pad_i.hv;
  end
endmodule

// File: rtl/drv_out_ctrl_chk.sv
`timescale 1ns/1ps
module drv_out_ctrl_chk #(
  parameter int N_OUT   = 10,
  parameter int HV_OUTS = 6
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cfg_latched,
  input logic [N_OUT-1:0] pd_en,
  input logic [N_OUT-1:0] wpu_en,
  input logic [N_OUT-1:0] pp_en,
  input logic [N_OUT-1:0] hv_en,
  input logic             tick_q,
  input logic             tick_wrap
);
  localparam logic [N_OUT-1:0] HV_MASK = N_OUT'((64'(1) << HV_OUTS) - 64'(1));

  // R2
  safe_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_latched |=> ((pd_en | wpu_en | pp_en | hv_en) == '0));

  // R7
  hv_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hv_en & ~HV_MASK) == '0);

  // R5
  no_fight_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pd_en & (wpu_en | pp_en | hv_en)) == '0);

  // R4
  single_pullup_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wpu_en & pp_en) == '0);

  // R9
  tick_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_latched |=> !tick_q);

  // R9
  tick_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(tick_q) |-> $past(tick_wrap));
endmodule

bind drv_out_ctrl drv_out_ctrl_chk #(.N_OUT(N_OUT), .HV_OUTS(HV_OUTS)) chk_i (
  .clk         (clk),
  .rst_n       (rst_n),
  .cfg_latched (cfg_latched),
  .pd_en       (pd_en),
  .wpu_en      (wpu_en),
  .pp_en       (pp_en),
  .hv_en       (hv_en),
  .tick_q      (tick_q),
  .tick_wrap   (tick_wrap)
);

// File: tb/drv_out_ctrl_tb_top.sv
`timescale 1ns/1ps
module drv_out_ctrl_tb_top;
  localparam int N    = 10;
  localparam int HV   = 6;
  localparam int HALF = 1250;

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic           cfg_latched = 1'b0;
  logic [N-1:0]   seq_data = '0;
  logic [N-1:0]   sw_data = '0;
  logic [N*7-1:0] cfg_word = '0;
  logic [N-1:0]   pd_en, wpu_en, pp_en, rail_up, hv_en;
  logic [2*N-1:0] rail_sel;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2 clk = ~clk;

  drv_out_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_latched(cfg_latched),
    .seq_data(seq_data), .sw_data(sw_data), .cfg_word(cfg_word),
    .pd_en(pd_en), .wpu_en(wpu_en), .pp_en(pp_en), .rail_up(rail_up),
    .rail_sel(rail_sel), .hv_en(hv_en)
  );

  // expected {pd, wpu, pp, rail_up, rail_sel[1:0], hv}
  function automatic logic [6:0] model(int pin, logic [6:0] cw, logic s, logic w, logic lat);
    logic [1:0] src  = cw[1:0];
    int         mode = int'(cw[4:2]);
    logic d;
    logic pd, wpu, pp, up, hv;
    logic [1:0] rs;
    if (!lat) return 7'b0;
    d = (src == 2'b00) ? s : (src == 2'b01) ? w : 1'b0;
    pd = (mode == 5) ? 1'b1 : (mode == 7) ? 1'b0 : !d;
    wpu = (mode == 1 || mode == 3) && d;
    pp  = (mode == 2 || mode == 4) && d;
    up  = (mode == 3 || mode == 4);
    rs  = up ? cw[6:5] : 2'b00;
    hv  = (mode == 6) && (pin < HV) && d;
    return {pd, wpu, pp, up, rs, hv};
  endfunction

  function automatic string tag_of(logic [6:0] cw, logic lat);
    if (!lat) return "R2";
    case (int'(cw[4:2]))
      0: return "R1+R3";
      1, 3: return "R1+R4";
      2, 4: return "R1+R5";
      5: return "R1+R6";
      6: return "R1+R7";
      default: return "R1+R8";
    endcase
  endfunction

  function automatic logic [6:0] got(int p);
    return {pd_en[p], wpu_en[p], pp_en[p], rail_up[p], rail_sel[2*p +: 2], hv_en[p]};
  endfunction

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic check_pins(logic [N*7-1:0] cw, logic [N-1:0] s, logic [N-1:0] w, logic lat);
    for (int p = 0; p < N; p++)
      check($sformatf("%s pin%0d", tag_of(cw[7*p +: 7], lat), p),
            32'(got(p)), 32'(model(p, cw[7*p +: 7], s[p], w[p], lat)));
  endtask

  task automatic apply(logic [N*7-1:0] cw, logic [N-1:0] s, logic [N-1:0] w, logic lat);
    cfg_word = cw; seq_data = s; sw_data = w; cfg_latched = lat;
    @(negedge clk);
    check_pins(cw, s, w, lat);
  endtask

  task automatic finish_run();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      finish_run();
    end
  end

  initial begin
    logic [N*7-1:0] cw;
    int k, h, l;
    void'($urandom(32'h5eed_0042));
    cfg_word = {N{7'b0001010}};
    seq_data = '1;
    cfg_latched = 1'b1;
    repeat (4) @(negedge clk);
    // R10: reset holds everything off
    check("R10 reset", 32'({pd_en, wpu_en, pp_en, rail_up, hv_en}), 32'd0);
    check("R10 reset rail", 32'(rail_sel), 32'd0);
    rst_n = 1'b1;

    // directed: high-voltage edge pads (R7), rail select (R4, R5), reserved (R8)
    cw = '0;
    for (int p = 0; p < N; p++) cw[7*p +: 7] = {2'b00, 3'd6, 2'b01};
    apply(cw, '0, '1, 1'b1);
    cw[7*3 +: 7] = {2'b10, 3'd3, 2'b00};
    cw[7*4 +: 7] = {2'b11, 3'd4, 2'b01};
    cw[7*7 +: 7] = {2'b00, 3'd7, 2'b00};
    cw[7*8 +: 7] = {2'b00, 3'd5, 2'b11};
    apply(cw, '1, '0, 1'b1);
    apply(cw, '0, '1, 1'b1);
    apply(cw, '1, '1, 1'b0);

    // random mix
    for (int it = 0; it < 1500; it++) begin
      logic [N-1:0] s, w;
      logic lat;
      for (int p = 0; p < N; p++) begin
        int r = $urandom % 3;
        logic [1:0] src = (r == 0) ? 2'b00 : (r == 1) ? 2'b01 : 2'b11;
        cw[7*p +: 7] = {2'($urandom), 3'($urandom), src};
      end
      s = N'($urandom);
      w = N'($urandom);
      lat = ($urandom % 8) != 0;
      apply(cw, s, w, lat);
    end

    // divided clock on every pad, push-pull to core
    cfg_word = {N{7'b0001010}};
    cfg_latched = 1'b0;
    repeat (3) @(negedge clk);
    check("R2 clock pads held off", 32'({pd_en, pp_en}), 32'd0);
    cfg_latched = 1'b1;
    k = 0;
    do begin
      @(negedge clk);
      k++;
    end while (!pp_en[0] && k < 3 * HALF);
    check("R9 first high delay", 32'(k), 32'(HALF + 1));
    check("R1 clock on all pads", 32'(pp_en), 32'({N{1'b1}}));
    h = 0;
    while (pp_en[0] && h < 3 * HALF) begin h++; @(negedge clk); end
    check("R9 high phase", 32'(h), 32'(HALF));
    check("R9 low-phase sink", 32'(pd_en), 32'({N{1'b1}}));
    l = 0;
    while (!pp_en[0] && l < 3 * HALF) begin l++; @(negedge clk); end
    check("R9 low phase", 32'(l), 32'(HALF));

    done = 1;
    finish_run();
  end
endmodule